// File: doc/BRIEF.md
# Flag-driven I2C byte controller

This block is a byte-level I2C master controller steered entirely by bits that software writes into a control register. Software raises a request (begin a transfer with a START, end it with a STOP, move one byte). The controller carries out exactly one protocol step on the open-drain SDA and SCL lines, loads an 8-bit status code that describes the new bus state, and sets a sticky interrupt flag. Until software clears that flag, the controller keeps SCL low and does nothing more. Each next step therefore begins only when software says so.

Three registers sit behind a small CPU port: control, data and status. The controller handles master transmit and master receive, including repeated START. The acknowledge level it returns while receiving comes from a control bit. A STOP request made while the controller does not own the bus acts as a "return to not-addressed slave" reset and touches no line. SCL is made by a fixed divider: four equal phases per bit, with PHASE_CYC clock cycles in each phase.

Top module: `i2cf_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 2) reads 0xF8, both line drives (sda_oe, scl_oe) are 0 and irq is 0.
- R2: Control bit 0 is the enable. While it is 0 the controller never drives SDA or SCL and a start request produces no bus activity.
- R3: With enable set, writing control bit 1 (start) on a free bus makes the controller issue a START (SDA falls while SCL is high). It then loads status 0x08, sets the flag and clears bit 1 itself.
- R4: A START seen on the bus marks it busy until a STOP is seen. A start request made while the bus is busy stays pending, with bit 1 still reading 1 and no line driven, and is carried out once the STOP appears.
- R5: Control bit 3 is the interrupt flag. Hardware sets it with every new status code other than 0xF8. Writing 0 to bit 3 clears it, and writing 1 leaves it unchanged.
- R6: irq is 1 exactly when the flag, glb_ie and own_ie are all 1.
- R7: While the flag is set and enable is 1, SCL is held low and the status code does not change.
- R8: After clearing the flag, a byte written to the data register (address 1) is shifted out MSB first. If it is the first byte after a START, status becomes 0x18/0x20 (bit 0 = 0, write, ACK/NACK) or 0x40/0x48 (bit 0 = 1, read, ACK/NACK). A later byte in write mode gives 0x28/0x30 (ACK/NACK).
- R9: In read mode a byte is shifted in and placed in the data register. When control bit 4 (acknowledge) is 1, SDA is driven low in the ninth clock and status becomes 0x50. When bit 4 is 0, SDA is left high and status becomes 0x58.
- R10: Setting start while the flag is being cleared, with the bus already owned, issues a repeated START and loads status 0x10.
- R11: Setting control bit 2 (stop) while the controller owns the bus drives a STOP. Bit 2 is cleared once the bus is seen free, the status returns to 0xF8, and the flag is not set.
- R12: Setting stop while the controller does not own the bus clears bit 2 without driving either line and without changing status or flag.
- R13: Control bit 5 (input disable) makes every sampled SDA bit read as 1, so an acknowledge is seen as NACK and received data reads 0xFF.
- R14: Every status code has its low three bits zero. While a byte or acknowledge bit is on the bus, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| glb_ie | input | 1 | Global interrupt enable |
| own_ie | input | 1 | Interrupt enable for this controller |
| sda_in | input | 1 | Sensed SDA level |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the local rules of the flag handshake: the flag only drops on a software clear, every new code raises it, SCL stays low while it is set, codes keep their low bits zero, SDA is stable while SCL is high inside a byte, and a START from idle only follows a free bus. Whole-transfer behaviour can only be shown by the bench's scenarios, where a behavioural slave on the wired bus acknowledges or refuses bytes, returns data and logs what it received. These include the status sequence for write, read and repeated START, the acknowledge level chosen by the control bit, input disable, a START held back by another master, and the slave-mode STOP that leaves the bus alone.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_ACK,
        ST_HOLD,
        ST_STOP
    } fsm_t;

    localparam logic [7:0] CODE_START      = 8'h08;
    localparam logic [7:0] CODE_RSTART     = 8'h10;
    localparam logic [7:0] CODE_ADR_W_ACK  = 8'h18;
    localparam logic [7:0] CODE_ADR_W_NACK = 8'h20;
    localparam logic [7:0] CODE_TX_ACK     = 8'h28;
    localparam logic [7:0] CODE_TX_NACK    = 8'h30;
    localparam logic [7:0] CODE_ADR_R_ACK  = 8'h40;
    localparam logic [7:0] CODE_ADR_R_NACK = 8'h48;
    localparam logic [7:0] CODE_RX_ACK     = 8'h50;
    localparam logic [7:0] CODE_RX_NACK    = 8'h58;
    localparam logic [7:0] CODE_NONE       = 8'hF8;

    typedef struct packed {
        fsm_t       st;
        logic [1:0] ph;
        logic [2:0] bitn;
        logic [7:0] sh;
        logic       smp;
        logic [7:0] dat;
        logic [7:0] stat;
        logic       en;
        logic       sta;
        logic       sto;
        logic       flag;
        logic       aa;
        logic       inoff;
        logic       master;
        logic       rd_mode;
        logic       addr_ph;
        logic       sda_hold;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, ph: 2'd0, bitn: 3'd0, sh: 8'h00, smp: 1'b0,
        dat: 8'h00, stat: CODE_NONE, en: 1'b0, sta: 1'b0, sto: 1'b0,
        flag: 1'b0, aa: 1'b0, inoff: 1'b0, master: 1'b0, rd_mode: 1'b0,
        addr_ph: 1'b0, sda_hold: 1'b0
    };

endpackage

// File: rtl/i2cf_phase_div.sv
module i2cf_phase_div #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST) && !clr;
        cnt_d = cnt_q;
        if (clr || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cf_bus_mon.sv
module i2cf_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sda_in,
    input  logic scl_in,
    output logic busy
);
    logic sda_d, sda_q, scl_d, scl_q, busy_d, busy_q;
    logic saw_start, saw_stop;

    always_comb begin
        saw_start = scl_in && scl_q && sda_q && !sda_in;
        saw_stop  = scl_in && scl_q && !sda_q && sda_in;
        sda_d     = sda_in;
        scl_d     = scl_in;
        busy_d    = busy_q;
        if (!en)            busy_d = 1'b0;
        else if (saw_start) busy_d = 1'b1;
        else if (saw_stop)  busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q  <= 1'b1;
            scl_q  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            sda_q  <= sda_d;
            scl_q  <= scl_d;
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/i2cf_ctrl.sv
module i2cf_ctrl #(
    parameter int PHASE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       glb_ie,
    input  logic       own_ie,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       sda_oe,
    output logic       scl_oe,
    output logic       irq
);
    import i2cf_pkg::*;

    ctl_t ctl_d, ctl_q;
    logic tick, busy, div_clr;
    logic rx, smp_now, got_ack, scl_lo, sda_lo;

    assign div_clr = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_HOLD);

    i2cf_phase_div #(.PHASE_CYC(PHASE_CYC)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (div_clr),
        .tick (tick)
    );

    i2cf_bus_mon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctl_q.en),
        .sda_in(sda_in),
        .scl_in(scl_in),
        .busy  (busy)
    );

    always_comb begin
        ctl_d   = ctl_q;
        rx      = ctl_q.rd_mode && !ctl_q.addr_ph;
        smp_now = ctl_q.inoff || sda_in;
        got_ack = !ctl_q.smp;

        // software side first; hardware updates below take priority
        if (reg_we) begin
            case (reg_addr)
                2'd0: begin
                    ctl_d.en    = reg_wdata[0];
                    ctl_d.sta   = reg_wdata[1];
                    ctl_d.sto   = reg_wdata[2];
                    ctl_d.flag  = ctl_q.flag && reg_wdata[3];
                    ctl_d.aa    = reg_wdata[4];
                    ctl_d.inoff = reg_wdata[5];
                end
                2'd1:    ctl_d.dat = reg_wdata;
                default: ;
            endcase
        end

        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.master = 1'b0;
                if (ctl_q.en && ctl_q.sta && !busy) begin
                    ctl_d.st = ST_START;
                    ctl_d.ph = 2'd1;
                end else if (ctl_q.en && ctl_q.sto) begin
                    ctl_d.sto = 1'b0;
                end
            end
            ST_START: if (tick) begin
                ctl_d.ph = ctl_q.ph + 2'd1;
                if (ctl_q.ph == 2'd3) begin
                    ctl_d.st       = ST_HOLD;
                    ctl_d.flag     = 1'b1;
                    ctl_d.stat     = ctl_q.master ? CODE_RSTART : CODE_START;
                    ctl_d.master   = 1'b1;
                    ctl_d.sta      = 1'b0;
                    ctl_d.addr_ph  = 1'b1;
                    ctl_d.rd_mode  = 1'b0;
                    ctl_d.sda_hold = 1'b1;
                end
            end
            ST_BITS: if (tick) begin
                ctl_d.ph = ctl_q.ph + 2'd1;
                if (ctl_q.ph == 2'd2) ctl_d.smp = smp_now;
                if (ctl_q.ph == 2'd3) begin
                    ctl_d.sh   = {ctl_q.sh[6:0], ctl_q.smp};
                    ctl_d.bitn = ctl_q.bitn + 3'd1;
                    if (ctl_q.bitn == 3'd7) ctl_d.st = ST_ACK;
                end
            end
            ST_ACK: if (tick) begin
                ctl_d.ph = ctl_q.ph + 2'd1;
                if (ctl_q.ph == 2'd2) ctl_d.smp = smp_now;
                if (ctl_q.ph == 2'd3) begin
                    ctl_d.st       = ST_HOLD;
                    ctl_d.flag     = 1'b1;
                    ctl_d.sda_hold = rx && ctl_q.aa;
                    if (ctl_q.addr_ph) begin
                        ctl_d.addr_ph = 1'b0;
                        ctl_d.rd_mode = ctl_q.dat[0];
                        if (ctl_q.dat[0]) ctl_d.stat = got_ack ? CODE_ADR_R_ACK : CODE_ADR_R_NACK;
                        else              ctl_d.stat = got_ack ? CODE_ADR_W_ACK : CODE_ADR_W_NACK;
                    end else if (ctl_q.rd_mode) begin
                        ctl_d.dat  = ctl_q.sh;
                        ctl_d.stat = ctl_q.aa ? CODE_RX_ACK : CODE_RX_NACK;
                    end else begin
                        ctl_d.stat = got_ack ? CODE_TX_ACK : CODE_TX_NACK;
                    end
                end
            end
            ST_HOLD: if (!ctl_q.flag) begin
                ctl_d.ph = 2'd0;
                if (ctl_q.sta) begin
                    ctl_d.st = ST_START;
                end else if (ctl_q.sto) begin
                    ctl_d.st = ST_STOP;
                end else begin
                    ctl_d.st   = ST_BITS;
                    ctl_d.bitn = 3'd0;
                    ctl_d.sh   = rx ? 8'h00 : ctl_q.dat;
                end
            end
            ST_STOP: if (tick) begin
                if (ctl_q.ph != 2'd3) begin
                    ctl_d.ph = ctl_q.ph + 2'd1;
                end else if (!busy) begin
                    ctl_d.st      = ST_IDLE;
                    ctl_d.sto     = 1'b0;
                    ctl_d.master  = 1'b0;
                    ctl_d.rd_mode = 1'b0;
                    ctl_d.stat    = CODE_NONE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (!ctl_q.en) begin
            ctl_d.st     = ST_IDLE;
            ctl_d.ph     = 2'd0;
            ctl_d.master = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    // line drive per state and phase
    always_comb begin
        scl_lo = 1'b0;
        sda_lo = 1'b0;
        case (ctl_q.st)
            ST_START: begin
                scl_lo = (ctl_q.ph == 2'd0) || (ctl_q.ph == 2'd3);
                sda_lo = ctl_q.ph[1];
            end
            ST_BITS: begin
                scl_lo = !ctl_q.ph[1];
                sda_lo = !rx && !ctl_q.sh[7];
            end
            ST_ACK: begin
                scl_lo = !ctl_q.ph[1];
                sda_lo = rx && ctl_q.aa;
            end
            ST_HOLD: begin
                scl_lo = 1'b1;
                sda_lo = ctl_q.sda_hold;
            end
            ST_STOP: begin
                scl_lo = (ctl_q.ph == 2'd0);
                sda_lo = !ctl_q.ph[1];
            end
            default: ;
        endcase
    end

    assign scl_oe = ctl_q.en && scl_lo;
    assign sda_oe = ctl_q.en && sda_lo;
    assign irq    = ctl_q.flag && glb_ie && own_ie;

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = {2'b00, ctl_q.inoff, ctl_q.aa, ctl_q.flag,
                                  ctl_q.sto, ctl_q.sta, ctl_q.en};
            2'd1:    reg_rdata = ctl_q.dat;
            2'd2:    reg_rdata = ctl_q.stat;
            default: reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/i2cf_ctrl_chk.sv
module i2cf_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       flag,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] stat,
    input logic       busy,
    input logic       in_idle,
    input logic       in_start,
    input logic       in_data
);
    a_r2_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> in_idle);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(reg_we && reg_addr == 2'd0 && !reg_wdata[3]) |=> flag);

    a_r5_code_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (stat != $past(stat)) && (stat != 8'hF8) |-> flag);

    a_r7_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
        en && flag |-> scl_oe);

    a_r14_code_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        stat[2:0] == 3'b000);

    a_r14_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        in_data && $past(in_data) && !scl_oe && $past(!scl_oe) |-> $stable(sda_oe));

    a_r4_start_needs_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
        in_start && $past(in_idle) |-> $past(!busy));
endmodule

bind i2cf_ctrl i2cf_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_q.en),
    .flag     (ctl_q.flag),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .stat     (ctl_q.stat),
    .busy     (busy),
    .in_idle  (ctl_q.st == i2cf_pkg::ST_IDLE),
    .in_start (ctl_q.st == i2cf_pkg::ST_START),
    .in_data  ((ctl_q.st == i2cf_pkg::ST_BITS) || (ctl_q.st == i2cf_pkg::ST_ACK))
);

// File: tb/i2cf_ctrl_bench.sv
module i2cf_ctrl_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       glb_ie = 1'b1, own_ie = 1'b0;
    logic       sda_oe, scl_oe, irq;
    logic       slv_pull = 1'b0, ext_sda = 1'b0;
    logic       sda_w, scl_w;

    assign sda_w = !(sda_oe || slv_pull || ext_sda);
    assign scl_w = !scl_oe;

    i2cf_ctrl #(.PHASE_CYC(4)) u_i2cf_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glb_ie(glb_ie),
        .own_ie(own_ie), .sda_in(sda_w), .scl_in(scl_w),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit model_en = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural slave and bus observer on the wired lines
    logic [7:0] rx_q[$];
    logic [7:0] tx_byte = 8'hC5;
    logic [7:0] shreg = 8'h00;
    bit ps = 1'b1, pc = 1'b1, sl_act = 1'b0, sl_addr = 1'b0, sl_rd = 1'b0;
    bit sending = 1'b0, m_ack = 1'b0, slv_ack_en = 1'b1;
    int bits = 0, start_cnt = 0, stop_cnt = 0;

    always @(negedge clk) begin
        if (scl_w && pc && ps && !sda_w) begin
            start_cnt++;
            sl_act = 1'b1; sl_addr = 1'b1; sl_rd = 1'b0;
            sending = 1'b0; bits = 0; slv_pull <= 1'b0;
        end else if (scl_w && pc && !ps && sda_w) begin
            stop_cnt++;
            sl_act = 1'b0; sending = 1'b0; slv_pull <= 1'b0;
        end else if (sl_act && scl_w && !pc) begin
            if (bits < 8) shreg = {shreg[6:0], sda_w};
            else if (sl_rd) m_ack = !sda_w;
            bits++;
        end else if (sl_act && !scl_w && pc) begin
            if (bits == 8) begin
                slv_pull <= !sl_rd && slv_ack_en;
            end else if (bits == 9) begin
                bits = 0;
                if (!sl_rd) begin
                    rx_q.push_back(shreg);
                    if (sl_addr) begin
                        sl_addr = 1'b0;
                        sl_rd   = shreg[0];
                        sending = shreg[0] && slv_ack_en;
                    end
                end else begin
                    sending = m_ack;
                end
                slv_pull <= sending && !tx_byte[7];
            end else if (bits >= 1 && bits <= 7 && sl_rd && sending) begin
                slv_pull <= !tx_byte[7 - bits];
            end
        end
        ps = sda_w;
        pc = scl_w;
    end

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!model_en) chk("R2 no drive while disabled", {30'd0, scl_oe, sda_oe}, 0);
            if (!glb_ie || !own_ie) chk("R6 irq gated", int'(irq), 0);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 2'd0) model_en = d[0];
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [7:0] cv(input bit en, input bit sta, input bit sto,
                                      input bit keep, input bit aa, input bit inoff);
        return {2'b00, inoff, aa, keep, sto, sta, en};
    endfunction

    task automatic step(input string req, input logic [7:0] code);
        logic [7:0] v;
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            rd(2'd0, v);
            seen = v[3];
        end
        chk({req, " flag set"}, int'(seen), 1);
        rd(2'd2, v);
        chk({req, " status"}, int'(v), int'(code));
        chk("R14 status low bits", int'(v[2:0]), 0);
    endtask

    task automatic wait_sto_clear(input string req);
        logic [7:0] v;
        bit clr = 1'b0;
        for (int i = 0; i < 3000 && !clr; i++) begin
            rd(2'd0, v);
            clr = !v[2];
        end
        chk({req, " stop bit cleared"}, int'(clr), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int s0, p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 control reset", int'(v), 8'h00);
        rd(2'd2, v); chk("R1 status reset", int'(v), 8'hF8);
        chk("R1 lines released", {30'd0, scl_oe, sda_oe}, 0);
        chk("R1 irq low", int'(irq), 0);

        // R2 start request with enable low
        wr(2'd0, cv(0, 1, 0, 1, 0, 0));
        repeat (200) @(negedge clk);
        chk("R2 no START", start_cnt, 0);
        rd(2'd2, v); chk("R2 status untouched", int'(v), 8'hF8);
        wr(2'd0, 8'h00);

        // R3 START, R6 irq, R7 stall, R5 sticky flag
        wr(2'd0, cv(1, 0, 0, 1, 0, 0));
        wr(2'd0, cv(1, 1, 0, 1, 0, 0));
        step("R3", 8'h08);
        chk("R3 START on bus", start_cnt, 1);
        rd(2'd0, v); chk("R3 start bit self-cleared", int'(v[1]), 0);
        chk("R6 irq off with own_ie=0", int'(irq), 0);
        own_ie = 1'b1;
        #1 chk("R6 irq on", int'(irq), 1);
        repeat (100) @(negedge clk);
        chk("R7 SCL held low", int'(scl_oe), 1);
        rd(2'd2, v); chk("R7 status frozen", int'(v), 8'h08);
        wr(2'd0, cv(1, 0, 0, 1, 0, 0));
        rd(2'd0, v); chk("R5 writing 1 keeps flag", int'(v[3]), 1);

        // R8 address write and data bytes
        wr(2'd1, 8'hA0); wr(2'd0, cv(1, 0, 0, 0, 0, 0));
        step("R8 addr write ack", 8'h18);
        chk("R6 irq with flag", int'(irq), 1);
        wr(2'd1, 8'h3C); wr(2'd0, cv(1, 0, 0, 0, 0, 0));
        step("R8 data ack", 8'h28);
        slv_ack_en = 1'b0;
        wr(2'd1, 8'h55); wr(2'd0, cv(1, 0, 0, 0, 0, 0));
        step("R8 data nack", 8'h30);
        slv_ack_en = 1'b1;

        // R10 repeated START
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        step("R10", 8'h10);
        chk("R10 second START seen", start_cnt, 2);

        // R8 / R9 read
        wr(2'd1, 8'hA1); wr(2'd0, cv(1, 0, 0, 0, 0, 0));
        step("R8 addr read ack", 8'h40);
        wr(2'd0, cv(1, 0, 0, 0, 1, 0));
        step("R9 rx with ack", 8'h50);
        rd(2'd1, v); chk("R9 rx data", int'(v), 8'hC5);
        chk("R9 slave saw ACK", int'(m_ack), 1);
        wr(2'd0, cv(1, 0, 0, 0, 0, 0));
        step("R9 rx with nack", 8'h58);
        rd(2'd1, v); chk("R9 rx data 2", int'(v), 8'hC5);
        chk("R9 slave saw NACK", int'(m_ack), 0);

        // R11 master STOP
        p0 = stop_cnt;
        wr(2'd0, cv(1, 0, 1, 0, 0, 0));
        wait_sto_clear("R11");
        chk("R11 STOP on bus", stop_cnt, p0 + 1);
        rd(2'd2, v); chk("R11 status idle", int'(v), 8'hF8);
        rd(2'd0, v); chk("R11 flag not set", int'(v[3]), 0);
        chk("R11 lines released", {30'd0, scl_oe, sda_oe}, 0);
        chk("R8 bytes at slave", rx_q.size(), 4);
        if (rx_q.size() == 4) begin
            chk("R8 byte0 MSB first", int'(rx_q[0]), 8'hA0);
            chk("R8 byte1", int'(rx_q[1]), 8'h3C);
            chk("R8 byte2", int'(rx_q[2]), 8'h55);
            chk("R8 byte3", int'(rx_q[3]), 8'hA1);
        end

        // R8 read address refused
        slv_ack_en = 1'b0;
        wr(2'd0, cv(1, 1, 0, 1, 0, 0));
        step("R8 start", 8'h08);
        wr(2'd1, 8'hA1); wr(2'd0, cv(1, 0, 0, 0, 0, 0));
        step("R8 addr read nack", 8'h48);
        wr(2'd0, cv(1, 0, 1, 0, 0, 0));
        wait_sto_clear("R8");
        slv_ack_en = 1'b1;

        // R13 input disable
        wr(2'd0, cv(1, 1, 0, 1, 0, 1));
        step("R13 start", 8'h08);
        wr(2'd1, 8'hA1); wr(2'd0, cv(1, 0, 0, 0, 0, 1));
        step("R13 ack read as NACK", 8'h48);
        wr(2'd0, cv(1, 0, 0, 0, 0, 1));
        step("R13 rx", 8'h58);
        rd(2'd1, v); chk("R13 data all ones", int'(v), 8'hFF);
        wr(2'd0, cv(1, 0, 1, 0, 0, 1));
        wait_sto_clear("R13");
        wr(2'd0, cv(1, 0, 0, 0, 0, 0));

        // R4 start held while another master owns the bus
        ext_sda = 1'b1;
        repeat (5) @(negedge clk);
        s0 = start_cnt;
        wr(2'd0, cv(1, 1, 0, 0, 0, 0));
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scl_oe || sda_oe) chk("R4 no drive while busy", {30'd0, scl_oe, sda_oe}, 0);
        end
        chk("R4 no START issued", start_cnt, s0);
        rd(2'd0, v); chk("R4 start pending", int'(v[1]), 1);
        rd(2'd2, v); chk("R4 status unchanged", int'(v), 8'hF8);
        ext_sda = 1'b0;
        step("R4 start after bus free", 8'h08);
        wr(2'd0, cv(1, 0, 1, 0, 0, 0));
        wait_sto_clear("R4");

        // R12 stop request without owning the bus
        s0 = start_cnt; p0 = stop_cnt;
        wr(2'd0, cv(1, 0, 1, 0, 0, 0));
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (scl_oe || sda_oe) chk("R12 no drive", {30'd0, scl_oe, sda_oe}, 0);
        end
        rd(2'd0, v); chk("R12 stop bit cleared", int'(v[2]), 0);
        chk("R12 flag untouched", int'(v[3]), 0);
        chk("R12 no bus conditions", start_cnt + stop_cnt, s0 + p0);
        rd(2'd2, v); chk("R12 status unchanged", int'(v), 8'hF8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule